// File: doc/BRIEF.md
# Paged Display RAM Access Port

This block is the host-facing path into a display memory laid out as pages. Each page holds one byte per column, and the eight bits of that byte light eight adjacent common rows within the page. After the eight data pages comes one extra indicator page, which keeps a single bit per column. The host sends one-cycle commands on a small command bus. The kind code is 0 to set the page, 1 to set the column, 2 to write data, 3 to read data, 4 to read status and 5 to set mirroring. Codes 6 and 7 are undefined. A write puts its byte at the current page and column. A read returns a byte one cycle after it is accepted. Both advance the column.

A second port, the refresh port, is used by the display scan logic. It reads the same memory at any time and never waits for the host. When mirroring is on, this port addresses the columns in reverse order. After every accepted command the block stays busy for a short fixed time. During that time it answers only status reads, which report the busy state on data bit 7.

Top module: `disp_ram_port`

## Requirements
- R1: When a clock edge samples `rst_n` low, the block clears the page to 0, the column to 0 and mirroring to off. `busy`, `rd_valid` and `ref_data` read 0 after that edge.
- R2: Set page (kind 0) loads `cmd_data[3:0]` into the page register and leaves the column counter unchanged.
- R3: Set column (kind 1) loads all 8 bits of `cmd_data` into the column counter and releases any lock.
- R4: Write (kind 2) stores `cmd_data` at (page, column). Read (kind 3) drives `rd_valid` high in the next cycle, with the stored byte on `rd_data`. Both add 1 to the column.
- R5: The column counter is locked while it is above 132 (0x84). In that state a write changes nothing, a read returns 0x00 and the counter holds its value. Only a set-column command releases it.
- R6: Page 8 is the indicator page. A write there keeps only bit 0, and a read returns bits 7..1 as 0. On pages 9..15 a write is dropped and a read returns 0x00, but the column still advances.
- R7: Kinds 0, 1, 2, 3 and 5 are accepted only while `busy` is low. An accepted command raises `busy` for the next BUSY_CYCLES cycles. Any other command that arrives while busy is ignored. Kinds 6 and 7 never change state.
- R8: A status read (kind 4) is accepted even while busy and does not start a busy period. In the next cycle `rd_valid` is high and `rd_data` carries the busy state of the request cycle in bit 7, with bits 6..0 at 0.
- R9: With `ref_en` high, `ref_data` shows the byte at (`ref_page`, column) in the next cycle. A page above 8 or a segment above 132 reads 0x00. With `ref_en` low, `ref_data` holds its value.
- R10: Mirror set (kind 5) takes its value from `cmd_data[0]`. While it is on, segment s reads column 132 - s. Host addressing is not affected.
- R11: If a host write hits the location that the refresh port reads in the same cycle, the refresh returns the new value. The refresh port is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 3 | Command code |
| cmd_data | input | 8 | Command operand or write byte |
| rd_valid | output | 1 | Read or status reply valid |
| rd_data | output | 8 | Reply byte |
| busy | output | 1 | Busy flag |
| ref_en | input | 1 | Refresh read request |
| ref_page | input | 4 | Refresh page |
| ref_seg | input | 8 | Refresh segment index |
| ref_data | output | 8 | Refresh byte, one cycle later |

## Verification
The assertions assume the host drives a known `cmd_kind` and `cmd_data` whenever `cmd_valid` is high. They also assume the refresh inputs stay stable across each clock edge. The stimulus changes every input only on the falling edge, so these assumptions always hold. Some command sequences are sent back to back, on purpose, so that the busy window actually rejects commands. The refresh sweep goes past the last page and the last segment so that the out-of-range zero replies are covered.

// File: rtl/drp_pkg.sv
// Shared definitions for the paged display RAM access port.
// Assumes a 3-bit command code on the host bus.
package drp_pkg;
    typedef enum logic [2:0] {
        K_PAGE   = 3'd0,
        K_COL    = 3'd1,
        K_WRITE  = 3'd2,
        K_READ   = 3'd3,
        K_STATUS = 3'd4,
        K_MIRROR = 3'd5,
        K_RSV6   = 3'd6,
        K_RSV7   = 3'd7
    } cmd_kind_e;

    // True for the command codes that are taken only while idle.
    function automatic logic needs_idle(input cmd_kind_e k);
        return (k == K_PAGE) || (k == K_COL) || (k == K_WRITE) ||
               (k == K_READ) || (k == K_MIRROR);
    endfunction
endpackage

// File: rtl/drp_addr_ctrl.sv
// Command decoder, page register, locking column counter and busy timer.
// It turns host commands into memory strobes and reply flags.
// Assumes COL_W <= 8, PAGE_W <= 8 and BUSY_CYCLES >= 1.
module drp_addr_ctrl #(
    parameter int COL_W       = 8,
    parameter int PAGE_W      = 4,
    parameter int DATA_PAGES  = 8,
    parameter int COL_MAX     = 132,
    parameter int BUSY_CYCLES = 2,
    parameter int IDX_W       = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_kind,
    input  logic [7:0]        cmd_data,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [IDX_W-1:0]  host_idx,
    output logic [7:0]        host_wdata,
    output logic              reply_v,
    output logic              reply_stat,
    output logic              reply_zero,
    output logic              busy,
    output logic              mirror_q,
    output logic [PAGE_W-1:0] page_q,
    output logic [COL_W-1:0]  col_q
);
    import drp_pkg::*;

    localparam int NUM_COLS = COL_MAX + 1;
    localparam int CNT_W    = $clog2(BUSY_CYCLES + 1);
    localparam logic [PAGE_W-1:0] IND_PG   = PAGE_W'(DATA_PAGES);
    localparam logic [COL_W-1:0]  COL_LAST = COL_W'(COL_MAX);
    localparam logic [IDX_W-1:0]  COLS_I   = IDX_W'(NUM_COLS);
    localparam logic [CNT_W-1:0]  BUSY_LD  = CNT_W'(BUSY_CYCLES);

    cmd_kind_e        kind;
    logic             accept;
    logic             access;
    logic             locked;
    logic             page_ok;
    logic [CNT_W-1:0] cnt_q;

    // Decode the command code and the address state.
    always_comb begin
        kind    = cmd_kind_e'(cmd_kind);
        busy    = (cnt_q != '0);
        accept  = cmd_valid && !busy && needs_idle(kind);
        access  = accept && ((kind == K_WRITE) || (kind == K_READ));
        locked  = (col_q > COL_LAST);
        page_ok = (page_q <= IND_PG);
    end

    // Build the memory strobes, the linear index and the write byte.
    always_comb begin
        mem_wr     = access && (kind == K_WRITE) && !locked && page_ok;
        mem_rd     = access && (kind == K_READ) && !locked && page_ok;
        host_idx   = IDX_W'(page_q) * COLS_I + IDX_W'(col_q);
        host_wdata = (page_q == IND_PG) ? {7'b0, cmd_data[0]} : cmd_data;
    end

    // Build the reply flags that the top registers.
    always_comb begin
        reply_stat = cmd_valid && (kind == K_STATUS);
        reply_v    = reply_stat || (access && (kind == K_READ));
        reply_zero = !reply_stat && !mem_rd;
    end

    // Busy timer: load on accept, count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (accept)   cnt_q <= BUSY_LD;
        else if (busy)     cnt_q <= cnt_q - 1'b1;
    end

    // Page register and mirror flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= '0;
            mirror_q <= 1'b0;
        end else if (accept && kind == K_PAGE) begin
            page_q   <= cmd_data[PAGE_W-1:0];
        end else if (accept && kind == K_MIRROR) begin
            mirror_q <= cmd_data[0];
        end
    end

    // Column counter: preset, auto-increment, hold once past the last column.
    always_ff @(posedge clk) begin
        if (!rst_n)                       col_q <= '0;
        else if (accept && kind == K_COL) col_q <= cmd_data[COL_W-1:0];
        else if (access && !locked)       col_q <= col_q + 1'b1;
    end
endmodule

// File: rtl/drp_seg_map.sv
// Maps a refresh (page, segment) pair to a linear memory index.
// Reverses the segment order when mirroring is on.
// Assumes segments 0..COL_MAX exist; any other value reads as zero.
module drp_seg_map #(
    parameter int COL_W      = 8,
    parameter int PAGE_W     = 4,
    parameter int DATA_PAGES = 8,
    parameter int COL_MAX    = 132,
    parameter int IDX_W      = 11
) (
    input  logic [PAGE_W-1:0] ref_page,
    input  logic [COL_W-1:0]  ref_seg,
    input  logic              mirror,
    output logic [IDX_W-1:0]  ref_idx,
    output logic              ref_ok
);
    localparam logic [PAGE_W-1:0] IND_PG   = PAGE_W'(DATA_PAGES);
    localparam logic [COL_W-1:0]  COL_LAST = COL_W'(COL_MAX);
    localparam logic [IDX_W-1:0]  COLS_I   = IDX_W'(COL_MAX + 1);

    logic [COL_W-1:0] col;

    // Select the RAM column for the segment and range-check the pair.
    always_comb begin
        col     = mirror ? (COL_LAST - ref_seg) : ref_seg;
        ref_ok  = (ref_page <= IND_PG) && (ref_seg <= COL_LAST);
        ref_idx = IDX_W'(ref_page) * COLS_I + IDX_W'(col);
    end
endmodule

// File: rtl/drp_store.sv
// Dual-port byte store. One port is for host read and write, the other
// is a read-only refresh port. A host write in the same cycle is
// forwarded to the refresh port. The array itself is not reset.
module drp_store #(
    parameter int DEPTH = 1197,
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [7:0]       wr_data,
    output logic [7:0]       host_q,
    input  logic             ref_en,
    input  logic             ref_ok,
    input  logic [IDX_W-1:0] ref_idx,
    output logic [7:0]       ref_q
);
    logic [7:0] mem [DEPTH];

    // Host write into the array.
    always_ff @(posedge clk) begin
        if (wr_en) mem[host_idx] <= wr_data;
    end

    // Registered host read.
    always_ff @(posedge clk) begin
        if (!rst_n)     host_q <= '0;
        else if (rd_en) host_q <= mem[host_idx];
    end

    // Registered refresh read with write forwarding and an out-of-range zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ref_q <= '0;
        else if (ref_en && !ref_ok)              ref_q <= '0;
        else if (ref_en && wr_en && host_idx == ref_idx) ref_q <= wr_data;
        else if (ref_en)                         ref_q <= mem[ref_idx];
    end
endmodule

// File: rtl/disp_ram_port.sv
// Top of the paged display RAM access port. It joins the command
// decoder, the refresh segment mapper and the dual-port store, and
// registers the host reply. Assumes single-cycle commands on cmd_valid.
module disp_ram_port #(
    parameter int COL_W       = 8,
    parameter int PAGE_W      = 4,
    parameter int DATA_PAGES  = 8,
    parameter int COL_MAX     = 132,
    parameter int BUSY_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_kind,
    input  logic [7:0]        cmd_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    input  logic              ref_en,
    input  logic [PAGE_W-1:0] ref_page,
    input  logic [COL_W-1:0]  ref_seg,
    output logic [7:0]        ref_data
);
    localparam int NUM_PAGES = DATA_PAGES + 1;
    localparam int DEPTH     = NUM_PAGES * (COL_MAX + 1);
    localparam int IDX_W     = $clog2(DEPTH);

    logic              mem_wr, mem_rd, reply_v, reply_stat, reply_zero, mirror_q;
    logic [IDX_W-1:0]  host_idx, ref_idx;
    logic [7:0]        host_wdata, host_q;
    logic              ref_ok;
    logic [PAGE_W-1:0] page_q;
    logic [COL_W-1:0]  col_q;
    logic              rsp_stat_q, rsp_busy_q, rsp_zero_q;

    drp_addr_ctrl #(
        .COL_W(COL_W), .PAGE_W(PAGE_W), .DATA_PAGES(DATA_PAGES),
        .COL_MAX(COL_MAX), .BUSY_CYCLES(BUSY_CYCLES), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_data(cmd_data), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .host_idx(host_idx), .host_wdata(host_wdata), .reply_v(reply_v),
        .reply_stat(reply_stat), .reply_zero(reply_zero), .busy(busy),
        .mirror_q(mirror_q), .page_q(page_q), .col_q(col_q)
    );

    drp_seg_map #(
        .COL_W(COL_W), .PAGE_W(PAGE_W), .DATA_PAGES(DATA_PAGES),
        .COL_MAX(COL_MAX), .IDX_W(IDX_W)
    ) u_map (
        .ref_page(ref_page), .ref_seg(ref_seg), .mirror(mirror_q),
        .ref_idx(ref_idx), .ref_ok(ref_ok)
    );

    drp_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(mem_wr), .rd_en(mem_rd),
        .host_idx(host_idx), .wr_data(host_wdata), .host_q(host_q),
        .ref_en(ref_en), .ref_ok(ref_ok), .ref_idx(ref_idx), .ref_q(ref_data)
    );

    // Register the kind of reply and the busy state seen with a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid   <= 1'b0;
            rsp_stat_q <= 1'b0;
            rsp_busy_q <= 1'b0;
            rsp_zero_q <= 1'b0;
        end else begin
            rd_valid   <= reply_v;
            rsp_stat_q <= reply_stat;
            rsp_busy_q <= busy;
            rsp_zero_q <= reply_zero;
        end
    end

    // Select the reply byte.
    always_comb begin
        if (rsp_stat_q)      rd_data = {rsp_busy_q, 7'b0};
        else if (rsp_zero_q) rd_data = 8'h00;
        else                 rd_data = host_q;
    end
endmodule

// File: rtl/drp_chk.sv
// Protocol checker for disp_ram_port, bound into every instance.
module drp_chk #(
    parameter int COL_W      = 8,
    parameter int PAGE_W     = 4,
    parameter int DATA_PAGES = 8,
    parameter int COL_MAX    = 132
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_kind,
    input logic              rd_valid,
    input logic [7:0]        rd_data,
    input logic              busy,
    input logic              ref_en,
    input logic [7:0]        ref_data,
    input logic [PAGE_W-1:0] page_q,
    input logic [COL_W-1:0]  col_q
);
    logic idle_kind;
    assign idle_kind = (cmd_kind != 3'd4) && (cmd_kind < 3'd6);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && idle_kind |=> busy);

    a_r7_col_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(col_q));

    a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (col_q > COL_W'(COL_MAX)) && !(cmd_valid && !busy && cmd_kind == 3'd1)
        |=> $stable(col_q));

    a_r2_page_keeps_col: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && cmd_kind == 3'd0 |=> $stable(col_q));

    a_r8_status_reply: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_kind == 3'd4
        |=> rd_valid && rd_data[6:0] == 7'd0 && rd_data[7] == $past(busy));

    a_r4_no_unasked_reply: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && (cmd_kind == 3'd3 || cmd_kind == 3'd4)) |=> !rd_valid);

    a_r6_indicator_read: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !busy && cmd_kind == 3'd3 && page_q == PAGE_W'(DATA_PAGES)
        |=> rd_data[7:1] == 7'd0);

    a_r9_ref_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |=> $stable(ref_data));
endmodule

bind disp_ram_port drp_chk #(
    .COL_W(COL_W), .PAGE_W(PAGE_W), .DATA_PAGES(DATA_PAGES), .COL_MAX(COL_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .ref_en(ref_en),
    .ref_data(ref_data), .page_q(page_q), .col_q(col_q)
);

// File: tb/disp_ram_port_tb.sv
// Bench with a behavioural reference model that is compared on every cycle.
module disp_ram_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 2;
    localparam int CMAX       = 132;
    localparam int NPG        = 9;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_kind = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic       rd_valid, busy;
    logic [7:0] rd_data, ref_data;
    logic       ref_en = 1'b0;
    logic [3:0] ref_page = 4'd0;
    logic [7:0] ref_seg = 8'd0;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string cur_req = "R1";
    bit sweep_on = 1'b0;

    // Reference model state.
    int m_mem [NPG*(CMAX+1)];
    bit m_known [NPG*(CMAX+1)];
    int m_page, m_col, m_cnt;
    bit m_mirror;
    bit e_rv;
    int e_rd;
    bit e_rd_known;
    string e_rd_tag;
    int e_ref;
    bit e_ref_known;
    string e_ref_tag;

    disp_ram_port #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_data(cmd_data), .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
        .ref_en(ref_en), .ref_page(ref_page), .ref_seg(ref_seg), .ref_data(ref_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp, input string what);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        int widx;
        bit wr;
        bit acc;
        int k;
        k = int'(cmd_kind);
        if (!rst_n) begin
            m_page = 0; m_col = 0; m_cnt = 0; m_mirror = 0;
            e_rv = 0; e_ref = 0; e_ref_known = 1; e_ref_tag = "R1";
        end else begin
            acc = cmd_valid && m_cnt == 0 && (k <= 3 || k == 5);
            wr = acc && k == 2 && m_col <= CMAX && m_page < NPG;
            widx = m_page * (CMAX + 1) + m_col;
            e_rv = 0;
            if (cmd_valid && k == 4) begin
                e_rv = 1; e_rd = (m_cnt != 0) ? 8'h80 : 0; e_rd_known = 1; e_rd_tag = "R8";
            end
            if (ref_en) begin
                if (ref_page < NPG && ref_seg <= CMAX) begin
                    int c, ri;
                    c = m_mirror ? CMAX - int'(ref_seg) : int'(ref_seg);
                    ri = int'(ref_page) * (CMAX + 1) + c;
                    if (wr && ri == widx) begin
                        e_ref = (m_page == 8) ? (cmd_data & 1) : cmd_data;
                        e_ref_known = 1; e_ref_tag = "R11";
                    end else begin
                        e_ref = m_mem[ri]; e_ref_known = m_known[ri];
                        e_ref_tag = m_mirror ? "R10" : "R9";
                    end
                end else begin
                    e_ref = 0; e_ref_known = 1; e_ref_tag = "R9";
                end
            end
            if (acc) begin
                case (k)
                    0: m_page = int'(cmd_data[3:0]);
                    1: m_col = int'(cmd_data);
                    5: m_mirror = cmd_data[0];
                    default: begin
                        if (k == 3) begin
                            e_rv = 1; e_rd_tag = cur_req; e_rd = 0; e_rd_known = 1;
                            if (m_col <= CMAX && m_page < NPG) begin
                                e_rd = m_mem[widx]; e_rd_known = m_known[widx];
                            end
                        end
                        if (wr) begin
                            m_mem[widx] = (m_page == 8) ? (cmd_data & 1) : cmd_data;
                            m_known[widx] = 1;
                        end
                        if (m_col <= CMAX) m_col++;
                    end
                endcase
                m_cnt = BUSY;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
        end
    end

    // Compare the outputs to the model on every falling edge.
    always @(negedge clk) begin
        cycles++;
        chk("R7", int'(busy), (m_cnt != 0) ? 1 : 0, "busy");
        chk(e_rv ? e_rd_tag : cur_req, int'(rd_valid), int'(e_rv), "rd_valid");
        if (e_rv && e_rd_known) chk(e_rd_tag, int'(rd_data), e_rd, "rd_data");
        if (e_ref_known) chk(e_ref_tag, int'(ref_data), e_ref, "ref_data");
    end

    // Refresh sweep that also covers out-of-range pages and segments.
    always @(negedge clk) begin
        if (sweep_on) begin
            ref_en   <= (cycles % 5) != 0;
            ref_page <= 4'((cycles / 3) % 11);
            ref_seg  <= 8'((cycles * 7) % 140);
        end else begin
            ref_en <= 1'b0;
        end
    end

    // Send one command and wait out its busy window.
    task automatic cmd(input int k, input int d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 3'(k); cmd_data = 8'(d);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (BUSY) @(negedge clk);
    endtask

    // Send one command for one cycle only.
    task automatic cmd_now(input int k, input int d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 3'(k); cmd_data = 8'(d);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(busy), 0, "busy after reset");
        chk("R1", int'(rd_valid), 0, "rd_valid after reset");
        chk("R1", int'(ref_data), 0, "ref_data after reset");
        cur_req = "R8";
        cmd(4, 0);
        // Fill every location while the refresh sweep runs (R4, R6, R11).
        sweep_on = 1'b1;
        cur_req = "R4";
        for (int p = 0; p < NPG; p++) begin
            cmd(0, p);
            cmd(1, 0);
            for (int c = 0; c <= CMAX; c++) cmd(2, (p * 37 + c * 11 + 5) & 8'hFF);
        end
        // Read back part of a data page (R4).
        cmd(0, 3); cmd(1, 0);
        for (int c = 0; c < 12; c++) cmd(3, 0);
        // Indicator page reads (R6).
        cur_req = "R6";
        cmd(0, 8); cmd(1, 4);
        for (int c = 0; c < 5; c++) cmd(3, 0);
        cmd(2, 8'hFE); cmd(2, 8'h03);
        cmd(1, 11); cmd(3, 0); cmd(3, 0);
        // Lock at the last column (R5, R3).
        cur_req = "R5";
        cmd(0, 1); cmd(1, 8'h82);
        cmd(2, 8'hA1); cmd(2, 8'hA2); cmd(2, 8'hA3); cmd(2, 8'hA4);
        cmd(3, 0); cmd(3, 0); cmd(2, 8'h55);
        cur_req = "R3";
        cmd(1, 8'h82);
        for (int c = 0; c < 4; c++) cmd(3, 0);
        cmd(1, 8'hF0); cmd(2, 8'h77); cmd(3, 0);
        cmd(1, 8'h00); cmd(3, 0);
        // Pages above the indicator (R6).
        cur_req = "R6";
        cmd(0, 12); cmd(1, 3); cmd(2, 8'h99); cmd(3, 0);
        cmd(0, 0); cmd(3, 0);
        // Busy rejection and status during busy (R7, R8).
        cur_req = "R7";
        cmd_now(0, 5); cmd_now(1, 40); cmd_now(4, 0); cmd_now(3, 0);
        cmd_now(3, 0); idle(BUSY + 1);
        cmd_now(6, 8'hFF); cmd_now(7, 3); cmd_now(3, 0); idle(BUSY + 1);
        // Page set keeps the column (R2).
        cur_req = "R2";
        cmd(1, 20); cmd(0, 4); cmd(3, 0); cmd(0, 6); cmd(3, 0);
        // Mirrored refresh for a while (R10).
        cur_req = "R10";
        cmd(5, 1);
        repeat (400) @(negedge clk);
        cmd(5, 0);
        repeat (100) @(negedge clk);
        sweep_on = 1'b0;
        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog for a hung run.
    initial begin
        #(CLK_PERIOD * 150000);
        compared++;
        mismatched++;
        $display("FAIL R7 watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule